// File: doc/BRIEF.md
# Multiprocessor-mode asynchronous serial transmitter

This block sends asynchronous serial frames on one output line for a multiprocessor link, where each frame carries an address/data flag bit right after the payload. Software puts a byte into the holding register and clears the transmit-empty flag. The block sees the cleared flag and copies the byte into its shift path. It sets the empty flag again and starts the frame.

A frame is one low start bit, then 7 or 8 payload bits sent least significant bit first, then the flag bit, then one or two high stop bits. The flag bit is 1 for an ID/address frame and 0 for a data frame. The block checks the empty flag again as the last stop bit ends. If new data is waiting, the next frame starts with no idle gap. If nothing is waiting, the block raises the transmit-end flag and holds the line at mark.

Both flags can drive level interrupt requests through per-flag enable inputs. An external baud-tick input sets the timing, and each bit lasts 16 ticks.

Top module: `mptx_top`

## Requirements
- R1: A frame on `tx_o` is, in time order: a 0 start bit, then the payload bits with the LSB first, then the `mpb_i` flag bit, then 1s for the stop bits. The payload is 8 bits when `short_i`=0 and 7 bits (bits 6..0) when `short_i`=1. There is one stop bit when `stop2_i`=0 and two when `stop2_i`=1.
- R2: While the line is idle, the block loads the holding register on the first cycle where `baud_tick_i`=1 and `empty_o`=0. On that same clock edge `empty_o` returns to 1 and `tx_o` goes to 0. Pulsing `empty_clr_i` sets `empty_o` to 0 on the next edge. `hold_we_i` writes the holding register and leaves `empty_o` unchanged.
- R3: `empty_irq_o` is 1 exactly while `empty_o`=1 and `empty_ie_i`=1.
- R4: If `empty_o`=0 on the tick that ends the last stop bit, the next frame's start bit begins on that same edge, with no idle time between the frames.
- R5: If `empty_o`=1 on the tick that ends the last stop bit, `end_o` becomes 1 on that edge and `tx_o` stays 1 until a new load.
- R6: `end_irq_o` is 1 exactly while `end_o`=1 and `end_ie_i`=1.
- R7: A pulse on `hold_we_i` or on `empty_clr_i` clears `end_o` on the next edge. A pulse on `hold_we_i` alone does not start a frame.
- R8: The data, `mpb_i`, `short_i` and `stop2_i` are captured at load. Changing these inputs during a frame does not alter that frame.
- R9: Each bit lasts 16 baud ticks. `tx_o` changes only on an edge where `baud_tick_i` was 1. After reset, `tx_o`=1, `empty_o`=1 and `end_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_tick_i | input | 1 | One-cycle pulse; 16 per bit |
| hold_we_i | input | 1 | Write strobe for the holding register |
| hold_data_i | input | 8 | Payload byte to write |
| empty_clr_i | input | 1 | Clears the transmit-empty flag |
| mpb_i | input | 1 | Flag bit value: 1 = address/ID frame, 0 = data frame |
| short_i | input | 1 | 1 = 7-bit payload, 0 = 8-bit payload |
| stop2_i | input | 1 | 1 = two stop bits, 0 = one |
| empty_ie_i | input | 1 | Enable for the transmit-empty interrupt |
| end_ie_i | input | 1 | Enable for the transmit-end interrupt |
| tx_o | output | 1 | Serial line, idles at 1 |
| empty_o | output | 1 | Transmit-empty flag |
| end_o | output | 1 | Transmit-end flag |
| empty_irq_o | output | 1 | Transmit-empty interrupt request, level |
| end_irq_o | output | 1 | Transmit-end interrupt request, level |

## Verification
The assertions check the following on every cycle:
- `tx_o` moves only after a baud tick.
- Every load begins with a low start bit.
- The line is at mark whenever no frame is active.
- The empty flag rises at each load.
- The end flag sets and clears as the flag rules say.

Some behaviour only the bench scenarios can show. These are the bit order and content of frames in both payload lengths and both stop counts. They also include the exact zero-gap timing of chained frames, the capture of the flag bit against later input changes, and the level behaviour of both interrupt requests as their enables toggle.

// File: rtl/mptx_pkg.sv
package mptx_pkg;
  localparam int unsigned OVS_DEF = 16;

  // bits in one frame: start + payload + flag + stops
  function automatic int unsigned frame_bits(int unsigned data_w, logic short_len, logic two_stop);
    return 1 + (short_len ? data_w - 1 : data_w) + 1 + (two_stop ? 2 : 1);
  endfunction
endpackage

// File: rtl/mptx_frame_fmt.sv
module mptx_frame_fmt #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned FRAME_W = DATA_W + 4,
  parameter int unsigned LEN_W   = $clog2(FRAME_W + 1)
) (
  input  logic [DATA_W-1:0]  data_i,
  input  logic               mpb_i,
  input  logic               short_i,
  input  logic               stop2_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [LEN_W-1:0]   len_o
);
  always_comb begin
    frame_o = '1;
    frame_o[0] = 1'b0;
    frame_o[DATA_W:1] = data_i;
    if (short_i) frame_o[DATA_W] = mpb_i;
    else         frame_o[DATA_W+1] = mpb_i;
    len_o = LEN_W'(mptx_pkg::frame_bits(DATA_W, short_i, stop2_i));
  end
endmodule

// File: rtl/mptx_shifter.sv
module mptx_shifter #(
  parameter int unsigned FRAME_W = 12,
  parameter int unsigned OVS     = mptx_pkg::OVS_DEF,
  parameter int unsigned LEN_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               pending_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [LEN_W-1:0]   len_i,
  output logic               load_o,
  output logic               done_o,
  output logic               tx_o
);
  localparam int unsigned CNT_W = $clog2(OVS);

  logic               busy_q;
  logic [CNT_W-1:0]   tick_cnt_q;
  logic [LEN_W-1:0]   left_q;
  logic [FRAME_W-1:0] sh_q;
  logic               tx_q;
  logic               bit_end, last_end;

  assign bit_end  = busy_q && tick_i && (tick_cnt_q == CNT_W'(OVS - 1));
  assign last_end = bit_end && (left_q == '0);
  // load from idle on a tick, or chained at the end of the last stop bit
  assign load_o   = tick_i && pending_i && (!busy_q || last_end);
  assign done_o   = last_end && !pending_i;
  assign tx_o     = tx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      tick_cnt_q <= '0;
      left_q     <= '0;
      sh_q       <= '1;
      tx_q       <= 1'b1;
    end else if (load_o) begin
      busy_q     <= 1'b1;
      tick_cnt_q <= '0;
      left_q     <= len_i - LEN_W'(1);
      sh_q       <= frame_i;
      tx_q       <= frame_i[0];
    end else if (done_o) begin
      busy_q     <= 1'b0;
      tick_cnt_q <= '0;
      tx_q       <= 1'b1;
    end else if (bit_end) begin
      tick_cnt_q <= '0;
      left_q     <= left_q - LEN_W'(1);
      sh_q       <= {1'b1, sh_q[FRAME_W-1:1]};
      tx_q       <= sh_q[1];
    end else if (busy_q && tick_i) begin
      tick_cnt_q <= tick_cnt_q + CNT_W'(1);
    end
  end

  AST_TX_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tx_q) |-> $past(tick_i)); // R9
  AST_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !tx_q); // R1
  AST_IDLE_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> tx_q); // R5
endmodule

// File: rtl/mptx_flags.sv
module mptx_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic done_i,
  input  logic hold_we_i,
  input  logic empty_clr_i,
  input  logic empty_ie_i,
  input  logic end_ie_i,
  output logic empty_o,
  output logic end_o,
  output logic empty_irq_o,
  output logic end_irq_o
);
  logic empty_q, end_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      empty_q <= 1'b1;
      end_q   <= 1'b1;
    end else begin
      if (load_i)           empty_q <= 1'b1;
      else if (empty_clr_i) empty_q <= 1'b0;
      // a software write wins over a same-cycle end
      if (hold_we_i || empty_clr_i) end_q <= 1'b0;
      else if (done_i)              end_q <= 1'b1;
    end
  end

  assign empty_o     = empty_q;
  assign end_o       = end_q;
  assign empty_irq_o = empty_q && empty_ie_i;
  assign end_irq_o   = end_q && end_ie_i;

  AST_EMPTY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> empty_q); // R2
  AST_EMPTY_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_clr_i && !load_i) |=> !empty_q); // R2
  AST_END_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !hold_we_i && !empty_clr_i) |=> end_q); // R5
  AST_END_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_we_i || empty_clr_i) |=> !end_q); // R7
endmodule

// File: rtl/mptx_top.sv
module mptx_top #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OVS    = mptx_pkg::OVS_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              baud_tick_i,
  input  logic              hold_we_i,
  input  logic [DATA_W-1:0] hold_data_i,
  input  logic              empty_clr_i,
  input  logic              mpb_i,
  input  logic              short_i,
  input  logic              stop2_i,
  input  logic              empty_ie_i,
  input  logic              end_ie_i,
  output logic              tx_o,
  output logic              empty_o,
  output logic              end_o,
  output logic              empty_irq_o,
  output logic              end_irq_o
);
  localparam int unsigned FRAME_W = DATA_W + 4;
  localparam int unsigned LEN_W   = $clog2(FRAME_W + 1);

  logic [DATA_W-1:0]  hold_q;
  logic [FRAME_W-1:0] frame;
  logic [LEN_W-1:0]   frame_len;
  logic               load, done, empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hold_q <= '0;
    else if (hold_we_i) hold_q <= hold_data_i;
  end

  mptx_frame_fmt #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_fmt (
    .data_i (hold_q),
    .mpb_i  (mpb_i),
    .short_i(short_i),
    .stop2_i(stop2_i),
    .frame_o(frame),
    .len_o  (frame_len)
  );

  mptx_shifter #(.FRAME_W(FRAME_W), .OVS(OVS), .LEN_W(LEN_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (baud_tick_i),
    .pending_i(!empty),
    .frame_i  (frame),
    .len_i    (frame_len),
    .load_o   (load),
    .done_o   (done),
    .tx_o     (tx_o)
  );

  mptx_flags u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .done_i     (done),
    .hold_we_i  (hold_we_i),
    .empty_clr_i(empty_clr_i),
    .empty_ie_i (empty_ie_i),
    .end_ie_i   (end_ie_i),
    .empty_o    (empty),
    .end_o      (end_o),
    .empty_irq_o(empty_irq_o),
    .end_irq_o  (end_irq_o)
  );

  assign empty_o = empty;
endmodule

// File: tb/mptx_top_tb.sv
module mptx_top_tb;
  typedef struct {
    logic [15:0] bits;
    int          len;
    bit          chained;
  } frame_t;

  logic clk = 0, rst_n = 0;
  logic tick = 0, hold_we = 0, empty_clr = 0, mpb = 0, short_len = 0, stop2 = 0;
  logic empty_ie = 0, end_ie = 0;
  logic [7:0] hold_data = 0;
  logic tx, empty, endf, empty_irq, end_irq;

  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;
  frame_t expq[$];
  frame_t cur;
  bit mon_busy = 0;
  int tcnt = 0, k = 0, ticks_since = 0, prev_len = 0;

  always #5 clk = ~clk;

  mptx_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .baud_tick_i(tick), .hold_we_i(hold_we),
    .hold_data_i(hold_data), .empty_clr_i(empty_clr), .mpb_i(mpb),
    .short_i(short_len), .stop2_i(stop2), .empty_ie_i(empty_ie), .end_ie_i(end_ie),
    .tx_o(tx), .empty_o(empty), .end_o(endf), .empty_irq_o(empty_irq), .end_irq_o(end_irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor first, then next tick value: tick holds what the last posedge saw
  always @(negedge clk) begin
    if (rst_n) begin
      if (tick) begin
        ticks_since++;
        if (mon_busy) begin
          tcnt++;
          if (tcnt == 8 + 16 * k) begin
            check(tx === cur.bits[k], $sformatf("R1/R9 bit %0d", k), int'(tx), int'(cur.bits[k]));
            k++;
            if (k == cur.len) mon_busy = 0;
          end
        end
      end
      if (!mon_busy && tx === 1'b0) begin
        if (expq.size() == 0) begin
          check(0, "R7 unexpected start", 0, 1);
          mon_busy = 1; cur.len = 1; cur.bits = '0; cur.chained = 0;
        end else begin
          cur = expq.pop_front();
          if (cur.chained)
            check(ticks_since == 16 * prev_len, "R4 gap", ticks_since, 16 * prev_len);
          mon_busy = 1;
        end
        prev_len = cur.len; tcnt = 0; k = 0; ticks_since = 0;
      end
    end
    cyc++;
    tick = (cyc % 4 == 3);
  end

  task automatic push(input logic [7:0] d, input bit m, input bit s7, input bit s2, input bit ch);
    frame_t f;
    int dl = s7 ? 7 : 8;
    f.bits = '1;
    f.bits[0] = 0;
    for (int i = 0; i < dl; i++) f.bits[1 + i] = d[i];
    f.bits[1 + dl] = m;
    f.len = dl + 2 + (s2 ? 2 : 1);
    f.chained = ch;
    expq.push_back(f);
  endtask

  task automatic send(input logic [7:0] d, input bit m, input bit s7, input bit s2, input bit ch);
    @(negedge clk);
    hold_data = d; mpb = m; short_len = s7; stop2 = s2;
    hold_we = 1; empty_clr = 1;
    push(d, m, s7, s2, ch);
    @(negedge clk);
    hold_we = 0; empty_clr = 0;
  endtask

  task automatic wait_load();
    int n = 0;
    while (!empty && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic wait_end();
    int n = 0;
    while (!endf && n < 20000) begin @(negedge clk); n++; end
    check(endf === 1'b1, "R5 end set", int'(endf), 1);
    check(tx === 1'b1 && !mon_busy && expq.size() == 0, "R5 mark after last frame", int'(tx), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(tx === 1 && empty === 1 && endf === 1, "R9 reset state", {tx, empty, endf}, 7);
    check(empty_irq === 0 && end_irq === 0, "R3/R6 irq off", {empty_irq, end_irq}, 0);
    rst_n = 1;
    @(negedge clk);
    empty_ie = 1; end_ie = 1;
    @(negedge clk);
    check(empty_irq === 1 && end_irq === 1, "R3/R6 irq level idle", {empty_irq, end_irq}, 3);

    // 8-bit, one stop, address frame
    send(8'hA5, 1, 0, 0, 0);
    check(empty === 0 && endf === 0 && empty_irq === 0, "R2/R7 after clear",
          {empty, endf, empty_irq}, 0);
    wait_load();
    check(tx === 0, "R2 start with load", int'(tx), 0);
    check(empty_irq === 1, "R3 irq at load", int'(empty_irq), 1);
    check(end_irq === 0, "R6 irq low while sending", int'(end_irq), 0);
    wait_end();
    check(end_irq === 1, "R6 end irq", int'(end_irq), 1);

    // 7-bit, two stop, data frame, chained with an 8-bit one
    send(8'hFF, 0, 1, 1, 0);
    wait_load();
    send(8'h3C, 1, 0, 0, 1);
    wait_load();
    check(empty_irq === 1, "R3 irq at chained load", int'(empty_irq), 1);
    empty_ie = 0;
    @(negedge clk);
    check(empty_irq === 0, "R3 irq follows enable", int'(empty_irq), 0);
    empty_ie = 1;
    wait_end();

    // write alone clears end, no frame
    @(negedge clk);
    hold_data = 8'h81; mpb = 0; short_len = 0; stop2 = 1; hold_we = 1;
    @(negedge clk);
    hold_we = 0;
    check(endf === 0 && end_irq === 0, "R7 write clears end", int'(endf), 0);
    repeat (200) @(negedge clk);
    check(tx === 1 && empty === 1 && !mon_busy, "R7 write alone no frame", int'(tx), 1);
    end_ie = 0;
    push(8'h81, 0, 0, 1, 0);
    empty_clr = 1;
    @(negedge clk);
    empty_clr = 0;
    wait_load();
    // inputs change during the frame: captured values stay
    mpb = 1; short_len = 1; stop2 = 0;
    wait_end();
    check(end_irq === 0, "R6 end irq masked", int'(end_irq), 0);

    // 7-bit, one stop, address frame
    send(8'h4E, 1, 1, 0, 0);
    wait_load();
    wait_end();
    check(tests > 0, "R8 capture frames compared", tests, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule